// File: doc/BRIEF.md
# Row/Column Strobed DRAM Doubleword Reader

This block reads 64-bit doublewords from a memory module made of eight byte-wide DRAM devices. Each device holds a small two-dimensional array of byte cells. A request address is split into a row index and a column index. Both indices go to every device over one shared narrow address bus, one after the other. First, a row strobe phase opens a row, and the device copies that whole row into its internal row buffer. Second, a column strobe phase picks one byte from the row buffer. The eight bytes returned in the same cycle are joined into one doubleword.

Requests arrive on a valid/ready port. A free-running timer asks for a refresh at a fixed interval. Each refresh opens the next row in turn and writes the row buffer back into the array. A refresh that is waiting is served before a new read. A read that has already started always runs to the end.

Top module: `dram_rd_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `req_ready` is 1 and `rd_done`, `ras_o` and `cas_o` are 0.
- R2: The row index is `req_addr[ROW_W+COL_W-1:COL_W]` and the column index is `req_addr[COL_W-1:0]`. During the row strobe `abus_o` carries the row index, and during the column strobe it carries the column index.
- R3: Once a request is accepted, `ras_o` is high for exactly RAS_CYC cycles, starting the cycle after acceptance. Then `cas_o` is high for exactly CAS_CYC cycles. The two strobes are never high together, and each phase lasts at least one cycle.
- R4: Device k supplies bits 8k+7..8k of `rd_data`. The cell at (row r, column c) of device k holds the byte {1'b1, k[2:0], r, c}.
- R5: `rd_done` is high for exactly one cycle, in the cycle right after the last column strobe cycle, and `rd_data` holds the doubleword in that cycle.
- R6: `req_ready` is 0 while either strobe is high, so no second request is taken during a read.
- R7: Every REF_PERIOD cycles a refresh is requested. A refresh drives `ras_o` for RAS_CYC cycles with `cas_o` low, with the refresh row on `abus_o`. Refresh rows go in ascending order and wrap to 0. When the block is idle, refresh row strobes start exactly REF_PERIOD cycles apart.
- R8: A waiting refresh lowers `req_ready`, and its row strobe runs before a request that is already waiting. A read in progress is never interrupted.
- R9: Refresh write-back leaves the array contents unchanged, so reads after refreshes return the R4 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request is accepted on this edge if valid |
| req_addr | input | ROW_W+COL_W | Doubleword address (row high, column low) |
| rd_done | output | 1 | One-cycle pulse: read data valid |
| rd_data | output | NDEV*DW | Gathered doubleword |
| ras_o | output | 1 | Row strobe seen by all devices |
| cas_o | output | 1 | Column strobe seen by all devices |
| abus_o | output | max(ROW_W,COL_W) | Shared multiplexed device address bus |

## Verification
The bench uses unequal strobe lengths, so a design that swaps the two phase counts, or overlaps the two phases, puts the wrong index on the bus in some cycle. It also walks addresses whose row and column differ, which catches a swapped split or a misordered byte lane in the returned data. A request is held while a refresh is waiting, to check that the refresh row appears first. A design that let the request jump ahead would show the request row instead. Long idle windows check the refresh period and the row order, and reads made after several refreshes would return corrupted bytes if the write-back stored the wrong row.

// File: rtl/drc_pkg.sv
package drc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_RROW,
        ST_RWB
    } seq_st_e;

    // Power-up content of a cell: {1, device, row, column}
    function automatic logic [7:0] fill_byte(int dev, int row, int col, int col_w);
        logic [7:0] v;
        v = 8'h80 | 8'(dev << 4) | 8'(row << col_w) | 8'(col);
        return v;
    endfunction

endpackage

// File: rtl/drc_ref_timer.sv
module drc_ref_timer #(
    parameter int PERIOD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        tick  = (tmr_q.cnt == CW'(PERIOD - 1));
        if (tick) tmr_d.cnt = '0;
        else      tmr_d.cnt = tmr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/drc_device.sv
module drc_device
    import drc_pkg::*;
#(
    parameter int DEV_ID = 0,
    parameter int ROW_W  = 2,
    parameter int COL_W  = 2,
    parameter int DW     = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      row_stb,
    input  logic                                      col_stb,
    input  logic                                      wb_stb,
    input  logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] abus,
    output logic [DW-1:0]                             dq
);
    localparam int ROWS = 1 << ROW_W;
    localparam int COLS = 1 << COL_W;

    typedef logic [COLS-1:0][DW-1:0] row_t;

    typedef struct packed {
        row_t [ROWS-1:0]   arr;
        row_t              rbuf;
        logic [ROW_W-1:0]  open_row;
    } dev_t;

    dev_t dev_d, dev_q;

    always_comb begin
        dev_d = dev_q;
        if (row_stb) begin
            dev_d.rbuf     = dev_q.arr[abus[ROW_W-1:0]];
            dev_d.open_row = abus[ROW_W-1:0];
        end
        if (wb_stb) begin
            dev_d.arr[dev_q.open_row] = dev_q.rbuf;
        end
        dq = col_stb ? dev_q.rbuf[abus[COL_W-1:0]] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    dev_q.arr[r][c] <= DW'(fill_byte(DEV_ID, r, c, COL_W));
                end
            end
            dev_q.rbuf     <= '0;
            dev_q.open_row <= '0;
        end else begin
            dev_q <= dev_d;
        end
    end
endmodule

// File: rtl/drc_seq.sv
module drc_seq
    import drc_pkg::*;
#(
    parameter int ROW_W   = 2,
    parameter int COL_W   = 2,
    parameter int RAS_CYC = 2,
    parameter int CAS_CYC = 2
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      req_valid,
    input  logic [ROW_W+COL_W-1:0]                    req_addr,
    output logic                                      req_ready,
    input  logic                                      ref_tick,
    output logic                                      row_stb,
    output logic                                      col_stb,
    output logic                                      wb_stb,
    output logic                                      cap_en,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] abus
);
    localparam int AW   = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int MAXC = (RAS_CYC > CAS_CYC) ? RAS_CYC : CAS_CYC;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

    typedef struct packed {
        seq_st_e          st;
        logic [CW-1:0]    cnt;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] ref_row;
        logic             ref_pend;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ref_tick) s_d.ref_pend = 1'b1;

        req_ready = (s_q.st == ST_IDLE) && !s_q.ref_pend;
        row_stb   = (s_q.st == ST_ROW) || (s_q.st == ST_RROW);
        col_stb   = (s_q.st == ST_COL);
        wb_stb    = (s_q.st == ST_RWB);
        cap_en    = (s_q.st == ST_COL) && (s_q.cnt == '0);

        unique case (s_q.st)
            ST_ROW:  abus = AW'(s_q.row);
            ST_COL:  abus = AW'(s_q.col);
            ST_RROW: abus = AW'(s_q.ref_row);
            default: abus = '0;
        endcase

        unique case (s_q.st)
            ST_IDLE: begin
                if (s_q.ref_pend) begin
                    s_d.st  = ST_RROW;
                    s_d.cnt = CW'(RAS_CYC - 1);
                end else if (req_valid) begin
                    s_d.row = req_addr[ROW_W+COL_W-1:COL_W];
                    s_d.col = req_addr[COL_W-1:0];
                    s_d.st  = ST_ROW;
                    s_d.cnt = CW'(RAS_CYC - 1);
                end
            end
            ST_ROW: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = ST_COL;
                    s_d.cnt = CW'(CAS_CYC - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                if (s_q.cnt == '0) s_d.st  = ST_IDLE;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            ST_RROW: begin
                if (s_q.cnt == '0) s_d.st  = ST_RWB;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            ST_RWB: begin
                s_d.st       = ST_IDLE;
                s_d.ref_row  = s_q.ref_row + 1'b1;
                s_d.ref_pend = ref_tick;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.st       <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/dram_rd_ctrl.sv
module dram_rd_ctrl #(
    parameter int NDEV       = 8,
    parameter int DW         = 8,
    parameter int ROW_W      = 2,
    parameter int COL_W      = 2,
    parameter int RAS_CYC    = 2,
    parameter int CAS_CYC    = 2,
    parameter int REF_PERIOD = 1000
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      req_valid,
    output logic                                      req_ready,
    input  logic [ROW_W+COL_W-1:0]                    req_addr,
    output logic                                      rd_done,
    output logic [NDEV*DW-1:0]                        rd_data,
    output logic                                      ras_o,
    output logic                                      cas_o,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] abus_o
);
    localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W;

    typedef struct packed {
        logic [NDEV*DW-1:0] data;
        logic               done;
    } out_t;

    out_t o_d, o_q;

    logic                     ref_tick;
    logic                     row_stb, col_stb, wb_stb, cap_en;
    logic [AW-1:0]            abus;
    logic [NDEV-1:0][DW-1:0]  dq_w;

    drc_ref_timer #(.PERIOD(REF_PERIOD)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_tick)
    );

    drc_seq #(
        .ROW_W   (ROW_W),
        .COL_W   (COL_W),
        .RAS_CYC (RAS_CYC),
        .CAS_CYC (CAS_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .ref_tick  (ref_tick),
        .row_stb   (row_stb),
        .col_stb   (col_stb),
        .wb_stb    (wb_stb),
        .cap_en    (cap_en),
        .abus      (abus)
    );

    for (genvar k = 0; k < NDEV; k++) begin : g_dev
        drc_device #(
            .DEV_ID (k),
            .ROW_W  (ROW_W),
            .COL_W  (COL_W),
            .DW     (DW)
        ) u_dev (
            .clk     (clk),
            .rst_n   (rst_n),
            .row_stb (row_stb),
            .col_stb (col_stb),
            .wb_stb  (wb_stb),
            .abus    (abus),
            .dq      (dq_w[k])
        );
    end

    always_comb begin
        o_d      = o_q;
        o_d.done = cap_en;
        if (cap_en) o_d.data = dq_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign rd_done = o_q.done;
    assign rd_data = o_q.data;
    assign ras_o   = row_stb;
    assign cas_o   = col_stb;
    assign abus_o  = abus;
endmodule

// File: rtl/drc_chk.sv
module drc_chk #(
    parameter int ROW_W   = 2,
    parameter int COL_W   = 2,
    parameter int RAS_CYC = 2,
    parameter int CAS_CYC = 2
) (
    input logic                                      clk,
    input logic                                      rst_n,
    input logic                                      req_valid,
    input logic                                      req_ready,
    input logic [ROW_W-1:0]                          req_row,
    input logic                                      rd_done,
    input logic                                      ras_o,
    input logic                                      cas_o,
    input logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] abus_o
);
    initial begin
        assert_phase_min_R3: assert (RAS_CYC >= 1 && CAS_CYC >= 1);
    end

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ras_o && cas_o));

    assert_col_after_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_o) |-> $past(ras_o));

    assert_row_on_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (ras_o && abus_o[ROW_W-1:0] == $past(req_row)));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    assert_done_after_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> $past(cas_o));

    assert_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_o || cas_o) |-> !req_ready);
endmodule

bind dram_rd_ctrl drc_chk #(
    .ROW_W   (ROW_W),
    .COL_W   (COL_W),
    .RAS_CYC (RAS_CYC),
    .CAS_CYC (CAS_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_row   (req_addr[ROW_W+COL_W-1:COL_W]),
    .rd_done   (rd_done),
    .ras_o     (ras_o),
    .cas_o     (cas_o),
    .abus_o    (abus_o)
);

// File: tb/sim_dram_rd_ctrl.sv
module sim_dram_rd_ctrl;
    localparam int CLK_P = 10;
    localparam int RAS   = 2;
    localparam int CAS   = 3;
    localparam int REF   = 200;

    // {address, expected doubleword}
    localparam logic [67:0] VECS [8] = '{
        {4'h0, 64'hF0E0D0C0B0A09080},
        {4'h5, 64'hF5E5D5C5B5A59585},
        {4'hA, 64'hFAEADACABAAA9A8A},
        {4'hF, 64'hFFEFDFCFBFAF9F8F},
        {4'h3, 64'hF3E3D3C3B3A39383},
        {4'hC, 64'hFCECDCCCBCAC9C8C},
        {4'h6, 64'hF6E6D6C6B6A69686},
        {4'h9, 64'hF9E9D9C9B9A99989}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_addr = '0;
    logic        rd_done;
    logic [63:0] rd_data;
    logic        ras_o, cas_o;
    logic [1:0]  abus_o;

    int n_vec = 0, n_bad = 0, cyc = 0;
    bit in_read = 1'b0, quiet = 1'b0, ref_on = 1'b0, done_flag = 1'b0;
    int ref_len = 0, ref_starts = 0, q_starts = 0, last_start = 0;
    logic [1:0] ref_row_exp = 2'd0;

    always #(CLK_P/2) clk = ~clk;

    dram_rd_ctrl #(
        .RAS_CYC    (RAS),
        .CAS_CYC    (CAS),
        .REF_PERIOD (REF)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .rd_done   (rd_done),
        .rd_data   (rd_data),
        .ras_o     (ras_o),
        .cas_o     (cas_o),
        .abus_o    (abus_o)
    );

    function automatic logic [63:0] exp_dw(logic [3:0] a);
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[8*k +: 8] = {1'b1, 3'(k), a};
        return v;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Called at a falling edge
    task automatic do_read(logic [3:0] a, logic [63:0] exp);
        req_addr  = a;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        in_read = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < RAS; i++) begin
            if (i > 0) @(negedge clk);
            chk(ras_o && !cas_o, "R3", "row phase strobes", {ras_o, cas_o}, 2'b10);
            chk(abus_o == a[3:2], "R2", "row on bus", abus_o, a[3:2]);
            chk(!req_ready, "R6", "ready during row", req_ready, 0);
        end
        for (int i = 0; i < CAS; i++) begin
            @(negedge clk);
            chk(cas_o && !ras_o, "R3", "column phase strobes", {ras_o, cas_o}, 2'b01);
            chk(abus_o == a[1:0], "R2", "column on bus", abus_o, a[1:0]);
            chk(!req_ready && !rd_done, "R6", "ready/done during column", {req_ready, rd_done}, 0);
        end
        @(negedge clk);
        chk(rd_done, "R5", "done after column phase", rd_done, 1);
        chk(rd_data == exp, "R4", "doubleword", rd_data, exp);
        chk(!ras_o && !cas_o, "R3", "strobes idle at done", {ras_o, cas_o}, 0);
        in_read = 1'b0;
        @(negedge clk);
        chk(!rd_done, "R5", "done one cycle", rd_done, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done_flag) begin
            chk(1'b0, "watchdog", "run did not end", cyc, 150000);
            finish_run();
        end
    end

    // Refresh observer: row strobes outside any read belong to refresh
    always @(negedge clk) begin
        if (rst_n) begin
            if (ras_o && !in_read) begin
                if (!ref_on) begin
                    ref_on = 1'b1;
                    ref_len = 0;
                    chk(abus_o == ref_row_exp, "R7", "refresh row order", abus_o, ref_row_exp);
                    ref_row_exp = ref_row_exp + 2'd1;
                    ref_starts++;
                    if (quiet) begin
                        q_starts++;
                        if (q_starts >= 3)
                            chk(cyc - last_start == REF, "R7", "refresh period", cyc - last_start, REF);
                        last_start = cyc;
                    end
                end
                ref_len++;
                chk(!cas_o && !req_ready, "R7", "refresh strobes/ready", {cas_o, req_ready}, 0);
            end else if (ref_on) begin
                ref_on = 1'b0;
                chk(ref_len == RAS, "R7", "refresh row strobe length", ref_len, RAS);
            end
        end
    end

    initial begin
        int s;
        repeat (3) @(negedge clk);
        chk(req_ready && !rd_done && !ras_o && !cas_o, "R1", "outputs in reset",
            {req_ready, rd_done, ras_o, cas_o}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rd_done && !ras_o && !cas_o, "R1", "outputs after reset",
            {req_ready, rd_done, ras_o, cas_o}, 4'b1000);

        // Table walk, repeated so refresh ticks land during reads (R8, R9)
        for (int rep = 0; rep < 5; rep++)
            for (int i = 0; i < 8; i++)
                do_read(VECS[i][67:64], VECS[i][63:0]);

        // Every address against the R4 content rule
        for (int a = 0; a < 16; a++) do_read(4'(a), exp_dw(4'(a)));

        // R8: a request presented while refresh waits is served after it
        while (!(!req_ready && !ras_o && !cas_o)) @(negedge clk);
        s = ref_starts;
        do_read(4'hE, exp_dw(4'hE));
        chk(ref_starts == s + 1, "R8", "refresh ran before waiting request", ref_starts, s + 1);

        // R7: idle window, refresh spacing
        q_starts = 0;
        quiet = 1'b1;
        repeat (4 * REF + 20) @(negedge clk);
        quiet = 1'b0;
        chk(q_starts >= 4, "R7", "refreshes seen while idle", q_starts, 4);

        // R9: contents intact after many write-backs
        chk(ref_starts >= 4, "R9", "all rows refreshed", ref_starts, 4);
        do_read(4'h0, exp_dw(4'h0));
        do_read(4'h7, exp_dw(4'h7));
        do_read(4'hB, exp_dw(4'hB));
        do_read(4'hD, exp_dw(4'hD));

        finish_run();
    end
endmodule